// File: doc/BRIEF.md
# Serial Configuration Chain Slave

This block takes part in a chain of devices that all load their configuration from one serial stream. It samples a data input on every rising edge of a shared configuration clock. It keeps the first `CFG_BITS` bits it receives as its own configuration word and then raises a flag to show that its load is complete. From then on it acts as a repeater. Every further bit it samples is sent out on a data output that feeds the data input of the next device in the chain. Each such bit changes on the falling edge of the clock, so the next device samples it half a cycle later on its own rising edge.

The block is active only when its three-bit mode input carries the serial-slave code `3'b111`. With any other code it ignores its data input. Its counter, its stored word and its flag stay as they are, and the data output idles high.

Control is a two-state machine. `ST_FILL` is the reset state, in which the block captures its own bits. The transition `FILL_DONE` moves it from `ST_FILL` to `ST_FWD` on the rising edge that captures the last own bit. `ST_FWD` is the forwarding state. It has one transition, `FWD_HOLD`, back to itself, and only the synchronous reset (`RESET_TO_FILL`) leaves it.

Top module: `cfgchain_slave`

## Requirements
- R1: When `rst` is high at a rising edge of `cclk`, the block clears `cfg_bits` to 0, clears `loaded` and the bit counter, and drives `dout` to 1 from the next falling edge.
- R2: While `mode` is `3'b111` and `loaded` is 0, each rising edge shifts `din` into `cfg_bits` at bit 0. After N = `CFG_BITS` captures, the bit received first (index 0) sits at `cfg_bits[N-1]` and bit i sits at `cfg_bits[N-1-i]`.
- R3: `loaded` goes to 1 right after the rising edge that captures the N-th own bit. It is 0 before that edge and stays 1 until a reset.
- R4: While `loaded` is 0, `dout` is 1. The N-th own bit is not forwarded either.
- R5: While `loaded` is 1 and `mode` is `3'b111`, a bit sampled on `din` at a rising edge drives `dout` from the following falling edge until the falling edge after that. `cfg_bits` no longer changes.
- R6: With `mode` not equal to `3'b111`, rising edges capture nothing. `cfg_bits`, `loaded` and the bit count hold their values, and `dout` is 1 from the next falling edge. A load that was paused resumes at the bit where it stopped.
- R7: When `dout` of one instance drives `din` of a second instance on the same `cclk`, a bit forwarded by the first from rising edge k is captured by the second at rising edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Shared configuration clock; capture on rising edge, forwarding on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Mode code; `3'b111` selects serial-slave operation |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device; high until loaded |
| loaded | output | 1 | High once the own configuration word is complete |
| cfg_bits | output | CFG_BITS | Captured configuration word |

## Verification
On every rising edge the assertions check several properties. `loaded` never falls without a reset. During a load, bit 0 of the word follows the previous `din`. The word and the flag freeze when the mode code is foreign or the block is loaded. `dout` is high before loading and, once loaded, repeats the previous cycle's `din`. Only the directed scenarios can show the things that need the whole stream. These are the final bit order of a complete word, the exact cycle on which `loaded` rises, a paused load resuming at the right bit, a reset in the middle of a load, and the one-cycle offset with which a second chained device picks up the forwarded bits.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

    // Mode code selecting serial-slave operation (configuration clock is an input)
    localparam logic [2:0] MODE_SER_SLAVE = 3'b111;

    // Control states of the chain slave
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,   // capturing own configuration bits
        ST_FWD  = 1'b1    // own word complete, repeating bits downstream
    } chain_state_t;

endpackage

// File: rtl/cfgchain_bitcount.sv
// Counts captured own bits and flags the step that completes the word.
module cfgchain_bitcount #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic last
);
    localparam int unsigned    CW  = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0]  TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last = step && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cfgchain_capture.sv
// Shift register holding the own configuration word; newest bit enters at bit 0.
module cfgchain_capture #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    generate
        if (WIDTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    word <= '0;
                end else if (shift_en) begin
                    word <= bit_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    word <= '0;
                end else if (shift_en) begin
                    word <= {word[WIDTH-2:0], bit_in};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfgchain_retime.sv
// Samples pass-through data on the rising edge and re-launches it on the falling edge.
module cfgchain_retime (
    input  logic clk,
    input  logic rst,
    input  logic pass_en,
    input  logic bit_in,
    output logic bit_out
);
    logic held_q;
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst || !pass_en) begin
            held_q <= 1'b1;
        end else begin
            held_q <= bit_in;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            out_q <= 1'b1;
        end else begin
            out_q <= held_q;
        end
    end

    assign bit_out = out_q;
endmodule

// File: rtl/cfgchain_slave.sv
// Serial configuration slave with daisy-chain pass-through.
module cfgchain_slave
    import cfgchain_pkg::*;
#(
    parameter int unsigned CFG_BITS = 8
) (
    input  logic                cclk,
    input  logic                rst,
    input  logic [2:0]          mode,
    input  logic                din,
    output logic                dout,
    output logic                loaded,
    output logic [CFG_BITS-1:0] cfg_bits
);
    chain_state_t state_q;
    chain_state_t state_d;

    logic mode_ok;
    logic capture_en;
    logic pass_en;
    logic last_bit;

    assign mode_ok = (mode == MODE_SER_SLAVE);

    // State register
    always_ff @(posedge cclk) begin
        if (rst) begin
            state_q <= ST_FILL;                 // RESET_TO_FILL
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (last_bit) state_d = ST_FWD;   // FILL_DONE
            ST_FWD:  state_d = ST_FWD;                 // FWD_HOLD
            default: state_d = ST_FILL;
        endcase
    end

    // Output / enable decode
    always_comb begin
        capture_en = 1'b0;
        pass_en    = 1'b0;
        loaded     = 1'b0;
        unique case (state_q)
            ST_FILL: capture_en = mode_ok;
            ST_FWD: begin
                pass_en = mode_ok;
                loaded  = 1'b1;
            end
            default: ;
        endcase
    end

    cfgchain_bitcount #(.LIMIT(CFG_BITS)) u_count (
        .clk  (cclk),
        .rst  (rst),
        .step (capture_en),
        .last (last_bit)
    );

    cfgchain_capture #(.WIDTH(CFG_BITS)) u_capture (
        .clk      (cclk),
        .rst      (rst),
        .shift_en (capture_en),
        .bit_in   (din),
        .word     (cfg_bits)
    );

    cfgchain_retime u_retime (
        .clk     (cclk),
        .rst     (rst),
        .pass_en (pass_en),
        .bit_in  (din),
        .bit_out (dout)
    );
endmodule

// File: rtl/cfgchain_slave_chk.sv
module cfgchain_slave_chk #(
    parameter int unsigned CFG_BITS = 8
) (
    input logic                cclk,
    input logic                rst,
    input logic [2:0]          mode,
    input logic                din,
    input logic                dout,
    input logic                loaded,
    input logic [CFG_BITS-1:0] cfg_bits
);
    // R3
    loaded_sticky_chk: assert property (@(posedge cclk) disable iff (rst)
        loaded |=> loaded);

    // R2
    shift_in_chk: assert property (@(posedge cclk) disable iff (rst)
        (mode == 3'b111 && !loaded) |=> (cfg_bits[0] == $past(din)));

    // R5
    word_frozen_chk: assert property (@(posedge cclk) disable iff (rst)
        loaded |=> $stable(cfg_bits));

    // R6
    mode_idle_chk: assert property (@(posedge cclk) disable iff (rst)
        (mode != 3'b111) |=> ($stable(cfg_bits) && $stable(loaded)));

    // R4
    idle_high_chk: assert property (@(posedge cclk) disable iff (rst)
        !loaded |-> dout);

    // R5
    repeat_bit_chk: assert property (@(posedge cclk) disable iff (rst)
        (loaded && mode == 3'b111) |=> (dout == $past(din)));
endmodule

bind cfgchain_slave cfgchain_slave_chk #(.CFG_BITS(CFG_BITS)) u_chk (
    .cclk     (cclk),
    .rst      (rst),
    .mode     (mode),
    .din      (din),
    .dout     (dout),
    .loaded   (loaded),
    .cfg_bits (cfg_bits)
);

// File: tb/sim_cfgchain_slave.sv
module sim_cfgchain_slave;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         cclk = 1'b0;
    logic         rst  = 1'b1;
    logic [2:0]   mode0 = 3'b000;
    logic [2:0]   mode1 = 3'b000;
    logic         din  = 1'b0;
    logic         dout0, dout1, loaded0, loaded1;
    logic [N-1:0] cfg0, cfg1;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) cclk = ~cclk;

    cfgchain_slave #(.CFG_BITS(N)) u0 (
        .cclk(cclk), .rst(rst), .mode(mode0), .din(din),
        .dout(dout0), .loaded(loaded0), .cfg_bits(cfg0)
    );

    cfgchain_slave #(.CFG_BITS(N)) u1 (
        .cclk(cclk), .rst(rst), .mode(mode1), .din(dout0),
        .dout(dout1), .loaded(loaded1), .cfg_bits(cfg1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive inputs just after a falling edge; return just after the next falling edge.
    task automatic tick(input logic b, input logic [2:0] m0, input logic [2:0] m1);
        din   = b;
        mode0 = m0;
        mode1 = m1;
        @(posedge cclk);
        @(negedge cclk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0, 3'b000, 3'b000);
        tick(1'b0, 3'b000, 3'b000);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(loaded0 == 1'b0, "R1 loaded", 32'(loaded0), 0);
        chk(cfg0 == '0, "R1 cfg_bits", 32'(cfg0), 0);
        chk(dout0 == 1'b1, "R1 dout", 32'(dout0), 1);
        chk(loaded1 == 1'b0 && cfg1 == '0, "R1 second", 32'(cfg1), 0);
    endtask

    // Load word w into u0, first bit = w[N-1]; u1 kept in a foreign mode.
    task automatic t_own_load(input logic [N-1:0] w);
        for (int i = 0; i < N; i++) begin
            tick(w[N-1-i], 3'b111, 3'b000);
            if (i == N - 2) begin
                chk(loaded0 == 1'b0, "R3 not yet loaded", 32'(loaded0), 0);
            end
            chk(dout0 == 1'b1, "R4 dout high while loading", 32'(dout0), 1);
        end
        chk(loaded0 == 1'b1, "R3 loaded after N bits", 32'(loaded0), 1);
        chk(cfg0 == w, "R2 captured word", 32'(cfg0), 32'(w));
        chk(loaded1 == 1'b0 && cfg1 == '0, "R6 second idle in foreign mode",
            32'(cfg1), 0);
    endtask

    // Stream f (first bit f[15]) through u0 into u1.
    task automatic t_forward(input logic [15:0] f);
        logic prev;
        tick(f[15], 3'b111, 3'b000);
        chk(dout0 == f[15], "R5 first forwarded bit", 32'(dout0), 32'(f[15]));
        prev = f[15];
        for (int j = 1; j <= 16; j++) begin
            logic b;
            b = (j < 16) ? f[15-j] : 1'b0;
            tick(b, 3'b111, 3'b111);
            if (j < 16) begin
                chk(dout0 == b, "R5 forwarded bit", 32'(dout0), 32'(b));
            end
            if (j < 8) begin
                chk(dout1 == 1'b1, "R4 second dout high", 32'(dout1), 1);
            end
            if (j == 7) begin
                chk(loaded1 == 1'b0, "R7 second not yet loaded", 32'(loaded1), 0);
            end
            if (j == 8) begin
                chk(loaded1 == 1'b1, "R7 second loaded", 32'(loaded1), 1);
                chk(cfg1 == f[15:8], "R7 second word", 32'(cfg1), 32'(f[15:8]));
            end
            if (j >= 9) begin
                chk(dout1 == prev, "R7 second forwards", 32'(dout1), 32'(prev));
            end
            prev = b;
        end
        chk(cfg0 == 8'hA6, "R5 first word unchanged", 32'(cfg0), 32'h A6);
    endtask

    task automatic t_mode_pause(input logic [N-1:0] w);
        do_reset();
        for (int i = 0; i < 3; i++) tick(w[N-1-i], 3'b111, 3'b000);
        chk(cfg0 == N'(w[N-1:N-3]), "R2 partial word", 32'(cfg0), 32'(w[N-1:N-3]));
        for (int i = 0; i < 4; i++) begin
            tick(i[0], 3'b011, 3'b000);
            chk(cfg0 == N'(w[N-1:N-3]), "R6 paused word", 32'(cfg0),
                32'(w[N-1:N-3]));
            chk(loaded0 == 1'b0, "R6 paused flag", 32'(loaded0), 0);
        end
        for (int i = 3; i < N; i++) tick(w[N-1-i], 3'b111, 3'b000);
        chk(cfg0 == w && loaded0, "R6 resumed load", 32'(cfg0), 32'(w));
        tick(1'b0, 3'b111, 3'b000);
        chk(dout0 == 1'b0, "R5 forwards zero", 32'(dout0), 0);
        tick(1'b0, 3'b101, 3'b000);
        chk(dout0 == 1'b1, "R6 dout high in foreign mode", 32'(dout0), 1);
        chk(loaded0 == 1'b1 && cfg0 == w, "R6 state held", 32'(cfg0), 32'(w));
    endtask

    task automatic t_reset_midload();
        do_reset();
        for (int i = 0; i < 5; i++) tick(1'b1, 3'b111, 3'b000);
        do_reset();
        chk(cfg0 == '0 && loaded0 == 1'b0, "R1 mid-load reset", 32'(cfg0), 0);
        // Counter must restart: N-1 more bits must not complete the load
        for (int i = 0; i < N - 1; i++) tick(1'b1, 3'b111, 3'b000);
        chk(loaded0 == 1'b0, "R1 counter cleared", 32'(loaded0), 0);
        tick(1'b0, 3'b111, 3'b000);
        chk(loaded0 == 1'b1 && cfg0 == 8'hFE, "R3 load after reset",
            32'(cfg0), 32'h FE);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1;
        t_reset();
        t_own_load(8'hA6);
        t_forward(16'hC35A);
        t_mode_pause(8'h5B);
        t_reset_midload();
        finish_run();
    end
endmodule